// File: doc/BRIEF.md
# Single-doubleword memory request decoder for a 128-bit packet receive stream

This block sits behind the receive side of a PCIe endpoint core. It takes transaction-layer packets from a 128-bit valid/ready stream and picks out the simple programmed-IO accesses: memory writes and memory reads with a 32-bit address (three-doubleword header) that move exactly one doubleword. A write becomes a single register-write transfer that carries an address and a 32-bit value. A read becomes a register-read transfer. That transfer carries the address, plus the requester ID and tag that a completion generator needs to route the answer back.

Every other packet is drained up to its last beat and has no effect. This covers 64-bit-address headers, IO, configuration and completion packets, and multi-doubleword requests. Wider host accesses reach the block as a series of one-doubleword requests whose addresses rise by 4, and the block handles each of them as an independent request.

Back-pressure works as follows. The block holds at most one decoded request. While a write or read transfer is waiting, `rx_ready` is low, so the upstream core cannot push more beats. Each output transfer completes on the clock edge where its valid and ready are both high. Until that edge the transfer's valid stays high and its fields stay unchanged.

Top module: `pio_req_decoder`

## Requirements
- R1: After reset, `rx_ready` is 1 and `wr_valid` and `rd_valid` are 0.
- R2: A header beat with type byte 0x40 in bits 31:24, Length 1 in bits 9:0, and byte-enable byte 0x0F in bits 39:32, followed by a data beat, yields exactly one write transfer. Its address is bits 95:64 of the header with bits 1:0 cleared, and its data is bits 31:0 of the data beat.
- R3: A header beat with type byte 0x00, Length 1 and byte-enable byte 0x0F yields exactly one read transfer. It carries the address from bits 95:64 with bits 1:0 cleared, the requester ID from bits 63:48 and the tag from bits 47:40.
- R4: A header with any other type byte produces no transfer, and all of its beats up to and including the one with `rx_last` are consumed.
- R5: A header whose Length (bits 9:0) is not 1 produces no transfer and is consumed through `rx_last`.
- R6: A header whose byte-enable byte (bits 39:32) is not 0x0F produces no transfer and is consumed through `rx_last`.
- R7: While a transfer's valid is high and its ready is low, the valid stays high and the transfer's fields do not change.
- R8: `rx_ready` is low exactly while a write or read transfer is pending. Beats are accepted only when `rx_valid` and `rx_ready` are both high.
- R9: A write header that carries `rx_last` (no data beat) produces no transfer.
- R10: Beats after a write's data beat, or after a read header, are consumed through `rx_last` without effect. The write or read itself is still issued.
- R11: Back-to-back requests produce transfers in arrival order, one for each accepted request.
- R12: `wr_valid` and `rd_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 128 | Packet beat; header doublewords 0..2 in bits 31:0, 63:32, 95:64 |
| rx_valid | input | 1 | Beat valid |
| rx_last | input | 1 | Final beat of the packet |
| rx_ready | output | 1 | Block can accept a beat |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Register side takes the write |
| wr_addr | output | 32 | Write byte address, doubleword aligned |
| wr_data | output | 32 | Write value |
| rd_valid | output | 1 | Register read pending |
| rd_ready | input | 1 | Read side takes the request |
| rd_addr | output | 32 | Read byte address, doubleword aligned |
| rd_req_id | output | 16 | Requester ID for the completion |
| rd_tag | output | 8 | Tag for the completion |

## Verification
Each internal state shows up at the ports within a cycle or two. If the receive state machine strays into the wrong phase, the next beat is misread: a data beat is taken as a header, a dropped packet leaks a transfer, or a valid request disappears. This shows up as a missing, extra or misordered transfer, compared one cycle after the beat is accepted. A holding slot that is stuck or cleared too early shows up on the very next cycle: either `rx_ready` disagrees with the count of pending transfers, or a stalled transfer changes. Ready patterns that alternate between stalls and immediate takes bring both of these faults out.

// File: rtl/pio_req_pkg.sv
package pio_req_pkg;
  localparam int DW_W = 32;
  localparam logic [7:0] TYPE_MWR32 = 8'h40;
  localparam logic [7:0] TYPE_MRD32 = 8'h00;
  localparam logic [7:0] BE_SINGLE  = 8'h0F;
  localparam logic [9:0] LEN_ONE    = 10'd1;

  typedef enum logic [1:0] {
    PH_HEADER = 2'd0,
    PH_DATA   = 2'd1,
    PH_DRAIN  = 2'd2
  } rx_phase_t;

  typedef enum logic [1:0] {
    REQ_WRITE = 2'd0,
    REQ_READ  = 2'd1,
    REQ_OTHER = 2'd2
  } req_kind_t;
endpackage

// File: rtl/pio_hdr_decode.sv
module pio_hdr_decode
  import pio_req_pkg::*;
#(
  parameter int BUS_W = 128
) (
  input  logic [BUS_W-1:0] beat,
  output req_kind_t        kind,
  output logic [DW_W-1:0]  addr,
  output logic [15:0]      req_id,
  output logic [7:0]       tag
);
  localparam int NUM_DW = BUS_W / DW_W;

  logic [DW_W-1:0] dw [NUM_DW];
  logic            shape_ok;

  generate
    for (genvar g = 0; g < NUM_DW; g++) begin : g_split
      assign dw[g] = beat[g*DW_W +: DW_W];
    end
  endgenerate

  always_comb begin
    shape_ok = (dw[0][9:0] == LEN_ONE) && (dw[1][7:0] == BE_SINGLE);
    if (shape_ok && dw[0][31:24] == TYPE_MWR32)      kind = REQ_WRITE;
    else if (shape_ok && dw[0][31:24] == TYPE_MRD32) kind = REQ_READ;
    else                                             kind = REQ_OTHER;
    addr   = {dw[2][31:2], 2'b00};
    req_id = dw[1][31:16];
    tag    = dw[1][15:8];
  end
endmodule

// File: rtl/pio_rx_ctrl.sv
module pio_rx_ctrl
  import pio_req_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  logic      last,
  input  req_kind_t kind,
  output logic      latch_addr,
  output logic      issue_wr,
  output logic      issue_rd
);
  rx_phase_t phase, phase_nxt;

  always_comb begin
    phase_nxt  = phase;
    latch_addr = 1'b0;
    issue_wr   = 1'b0;
    issue_rd   = 1'b0;
    if (fire) begin
      case (phase)
        PH_HEADER: begin
          case (kind)
            REQ_WRITE: if (!last) begin
              latch_addr = 1'b1;
              phase_nxt  = PH_DATA;
            end
            REQ_READ: begin
              issue_rd  = 1'b1;
              phase_nxt = last ? PH_HEADER : PH_DRAIN;
            end
            default: phase_nxt = last ? PH_HEADER : PH_DRAIN;
          endcase
        end
        PH_DATA: begin
          issue_wr  = 1'b1;
          phase_nxt = last ? PH_HEADER : PH_DRAIN;
        end
        PH_DRAIN: if (last) phase_nxt = PH_HEADER;
        default:  phase_nxt = PH_HEADER;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_HEADER;
    else        phase <= phase_nxt;
  end

  AST_DATA_ONLY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    issue_wr |-> $past(latch_addr) || $past(phase == PH_DATA)) else $error("write without header"); // R2
endmodule

// File: rtl/pio_out_slot.sv
module pio_out_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        q     <= din;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(q)) else $error("slot changed under stall"); // R7
  AST_SLOT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid) else $error("slot loaded while full"); // R8
endmodule

// File: rtl/pio_req_decoder.sv
module pio_req_decoder
  import pio_req_pkg::*;
#(
  parameter int BUS_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] rx_data,
  input  logic             rx_valid,
  input  logic             rx_last,
  output logic             rx_ready,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [31:0]      wr_addr,
  output logic [31:0]      wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [31:0]      rd_addr,
  output logic [15:0]      rd_req_id,
  output logic [7:0]       rd_tag
);
  localparam int WR_W = 2 * DW_W;
  localparam int RD_W = DW_W + 16 + 8;

  req_kind_t       kind;
  logic [DW_W-1:0] hdr_addr;
  logic [15:0]     hdr_id;
  logic [7:0]      hdr_tag;
  logic            fire, latch_addr, issue_wr, issue_rd;
  logic [DW_W-1:0] held_addr;
  logic [WR_W-1:0] wr_q;
  logic [RD_W-1:0] rd_q;

  assign rx_ready = !wr_valid && !rd_valid;
  assign fire     = rx_valid && rx_ready;

  pio_hdr_decode #(.BUS_W(BUS_W)) u_dec (
    .beat(rx_data), .kind(kind), .addr(hdr_addr), .req_id(hdr_id), .tag(hdr_tag)
  );

  pio_rx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(rx_last), .kind(kind),
    .latch_addr(latch_addr), .issue_wr(issue_wr), .issue_rd(issue_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          held_addr <= '0;
    else if (latch_addr) held_addr <= hdr_addr;
  end

  pio_out_slot #(.W(WR_W)) u_wr_slot (
    .clk(clk), .rst_n(rst_n), .load(issue_wr),
    .din({held_addr, rx_data[DW_W-1:0]}),
    .ready(wr_ready), .valid(wr_valid), .q(wr_q)
  );

  pio_out_slot #(.W(RD_W)) u_rd_slot (
    .clk(clk), .rst_n(rst_n), .load(issue_rd),
    .din({hdr_addr, hdr_id, hdr_tag}),
    .ready(rd_ready), .valid(rd_valid), .q(rd_q)
  );

  assign {wr_addr, wr_data}          = wr_q;
  assign {rd_addr, rd_req_id, rd_tag} = rd_q;

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid)) else $error("both outputs pending"); // R12
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || rd_valid) |-> !rx_ready) else $error("ready while busy"); // R8
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00) else $error("unaligned write"); // R2
  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[1:0] == 2'b00) else $error("unaligned read"); // R3
endmodule

// File: tb/pio_req_decoder_tb.sv
module pio_req_decoder_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] rx_data = '0;
  logic         rx_valid = 1'b0, rx_last = 1'b0;
  logic         rx_ready;
  logic         wr_valid, rd_valid;
  logic         wr_ready = 1'b1, rd_ready = 1'b1;
  logic [31:0]  wr_addr, wr_data, rd_addr;
  logic [15:0]  rd_req_id;
  logic [7:0]   rd_tag;

  int total = 0, bad = 0;
  int wr_seen = 0, rd_seen = 0;
  int stall_mode = 0;
  int mphase = 0;
  logic [31:0] maddr;
  logic [63:0] wq[$];
  logic [55:0] rq[$];
  bit prev_wr_stall = 0, prev_rd_stall = 0;
  logic [63:0] prev_wr;
  logic [55:0] prev_rd;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pio_req_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_ready(rx_ready), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_req_id(rd_req_id), .rd_tag(rd_tag)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] hdr(input logic [7:0] ty, input logic [9:0] len,
                                       input logic [7:0] be, input logic [15:0] id,
                                       input logic [7:0] tg, input logic [31:0] a);
    return {32'h0, a, id, tg, be, ty, 14'h0, len};
  endfunction

  // behavioural reference: decode each accepted beat from the requirements
  task automatic model_beat(input logic [127:0] d, input bit l);
    bit ok;
    ok = (d[9:0] == 10'd1) && (d[39:32] == 8'h0F);
    case (mphase)
      0: begin
        if (ok && d[31:24] == 8'h40) begin
          if (!l) begin maddr = d[95:64] & ~32'h3; mphase = 1; end
        end else if (ok && d[31:24] == 8'h00) begin
          rq.push_back({d[95:64] & ~32'h3, d[63:48], d[47:40]});
          mphase = l ? 0 : 2;
        end else mphase = l ? 0 : 2;
      end
      1: begin
        wq.push_back({maddr, d[31:0]});
        mphase = l ? 0 : 2;
      end
      default: if (l) mphase = 0;
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(rx_ready == (wq.size() == 0 && rq.size() == 0), "R8 ready vs pending",
          rx_ready, (wq.size() == 0 && rq.size() == 0));
      chk(!(wr_valid && rd_valid), "R12 both valid", {wr_valid, rd_valid}, 2'b00);
      chk(wr_valid == (wq.size() != 0), "R11 write presence", wr_valid, wq.size() != 0);
      chk(rd_valid == (rq.size() != 0), "R11 read presence", rd_valid, rq.size() != 0);
      if (wr_valid && wq.size() != 0)
        chk({wr_addr, wr_data} == wq[0], "R2 write fields", {wr_addr, wr_data}, wq[0]);
      if (rd_valid && rq.size() != 0)
        chk({rd_addr, rd_req_id, rd_tag} == rq[0], "R3 read fields",
            {rd_addr, rd_req_id, rd_tag}, rq[0]);
      if (prev_wr_stall)
        chk(wr_valid && {wr_addr, wr_data} == prev_wr, "R7 write held",
            {wr_valid, wr_addr, wr_data}, {1'b1, prev_wr});
      if (prev_rd_stall)
        chk(rd_valid && {rd_addr, rd_req_id, rd_tag} == prev_rd, "R7 read held",
            {rd_valid, rd_addr, rd_req_id, rd_tag}, {1'b1, prev_rd});
      prev_wr_stall = wr_valid && !wr_ready;
      prev_rd_stall = rd_valid && !rd_ready;
      prev_wr = {wr_addr, wr_data};
      prev_rd = {rd_addr, rd_req_id, rd_tag};
      if (wr_valid && wr_ready && wq.size() != 0) begin void'(wq.pop_front()); wr_seen++; end
      if (rd_valid && rd_ready && rq.size() != 0) begin void'(rq.pop_front()); rd_seen++; end
      if (rx_valid && rx_ready) model_beat(rx_data, rx_last);
    end
  end

  always @(posedge clk) begin
    #1;
    case (stall_mode)
      0: begin wr_ready = 1'b1; rd_ready = 1'b1; end
      1: begin wr_ready = ($urandom_range(0, 2) == 0); rd_ready = ($urandom_range(0, 2) == 0); end
      default: begin wr_ready = 1'b0; rd_ready = 1'b0; end
    endcase
  end

  task automatic beat(input logic [127:0] d, input bit l);
    rx_data = d; rx_last = l; rx_valid = 1'b1;
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (wq.size() != 0 || rq.size() != 0 || rx_ready !== 1'b1) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic expect_none(input string req, input int w0, input int r0);
    settle();
    chk(wr_seen == w0 && rd_seen == r0, req, {wr_seen, rd_seen}, {w0, r0});
  endtask

  initial begin
    int w0, r0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready && !wr_valid && !rd_valid, "R1 reset state", {rx_ready, wr_valid, rd_valid}, 3'b100);
    @(posedge clk); #1;

    // R2 R11: host 12-byte write split into three aligned requests
    for (int i = 0; i < 3; i++) begin
      beat(hdr(8'h40, 10'd1, 8'h0F, 16'h0000, 8'(i), 32'hDF20_2000 + 32'(4 * i)), 1'b0);
      beat({96'h0, 32'h0102_0304 + 32'(i * 32'h0404_0404)}, 1'b1);
    end
    settle();
    chk(wr_seen == 3, "R11 three writes", wr_seen, 3);

    // R3: three reads, distinct IDs and tags, low address bits set
    for (int i = 0; i < 3; i++)
      beat(hdr(8'h00, 10'd1, 8'h0F, 16'h0100 + 16'(i), 8'h10 + 8'(i), 32'hDF20_2003 + 32'(4 * i)), 1'b1);
    settle();
    chk(rd_seen == 3, "R3 three reads", rd_seen, 3);

    // R4: other types dropped (64-bit write, config, completion), multi-beat
    w0 = wr_seen; r0 = rd_seen;
    beat(hdr(8'h60, 10'd1, 8'h0F, 16'h1, 8'h1, 32'h1000), 1'b0);
    beat({96'h0, 32'hAAAA_AAAA}, 1'b0);
    beat({96'h0, 32'hBBBB_BBBB}, 1'b1);
    beat(hdr(8'h04, 10'd1, 8'h0F, 16'h1, 8'h2, 32'h2000), 1'b1);
    beat(hdr(8'h4A, 10'd1, 8'h0F, 16'h1, 8'h3, 32'h3000), 1'b0);
    beat({96'h0, 32'h0102_0304}, 1'b1);
    expect_none("R4 other type dropped", w0, r0);

    // R5: Length not 1
    beat(hdr(8'h40, 10'd2, 8'h0F, 16'h1, 8'h4, 32'h4000), 1'b0);
    beat({64'h0, 64'h1111_2222_3333_4444}, 1'b1);
    beat(hdr(8'h00, 10'd0, 8'h0F, 16'h1, 8'h5, 32'h4004), 1'b1);
    expect_none("R5 length dropped", w0, r0);

    // R6: byte enables other than 0x0F
    beat(hdr(8'h40, 10'd1, 8'h03, 16'h1, 8'h6, 32'h5000), 1'b0);
    beat({96'h0, 32'h5555_5555}, 1'b1);
    beat(hdr(8'h00, 10'd1, 8'hFF, 16'h1, 8'h7, 32'h5004), 1'b1);
    expect_none("R6 byte enable dropped", w0, r0);

    // R9: write header with no data beat, then a good read must decode as header
    beat(hdr(8'h40, 10'd1, 8'h0F, 16'h1, 8'h8, 32'h6000), 1'b1);
    expect_none("R9 dataless write dropped", w0, r0);
    beat(hdr(8'h00, 10'd1, 8'h0F, 16'hBEEF, 8'h99, 32'h6004), 1'b1);
    settle();
    chk(rd_seen == r0 + 1, "R9 next header decoded", rd_seen, r0 + 1);

    // R10: trailing beats after data / after read header
    w0 = wr_seen; r0 = rd_seen;
    beat(hdr(8'h40, 10'd1, 8'h0F, 16'h2, 8'h1, 32'h7000), 1'b0);
    beat({96'h0, 32'hCAFE_F00D}, 1'b0);
    beat(hdr(8'h40, 10'd1, 8'h0F, 16'h2, 8'h2, 32'h7100), 1'b0);
    beat({96'h0, 32'hDEAD_BEEF}, 1'b1);
    beat(hdr(8'h00, 10'd1, 8'h0F, 16'h3, 8'h3, 32'h7200), 1'b0);
    beat(hdr(8'h40, 10'd1, 8'h0F, 16'h3, 8'h4, 32'h7300), 1'b1);
    settle();
    chk(wr_seen == w0 + 1 && rd_seen == r0 + 1, "R10 trailing beats ignored",
        {wr_seen, rd_seen}, {w0 + 1, r0 + 1});

    // R7 R8: full stall, then random back-pressure on mixed traffic
    stall_mode = 2;
    rx_data = hdr(8'h00, 10'd1, 8'h0F, 16'h4444, 8'h44, 32'h8000); rx_last = 1'b1; rx_valid = 1'b1;
    repeat (6) @(posedge clk);
    #1 rx_valid = 1'b0;
    @(negedge clk);
    chk(rd_valid && !rx_ready, "R8 stalled read blocks input", {rd_valid, rx_ready}, 2'b10);
    stall_mode = 1;
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 1) beat(hdr(8'h00, 10'd1, 8'h0F, 16'(i), 8'(i), 32'h9000 + 32'(4 * i)), 1'b1);
      else if (i % 5 == 4) beat(hdr(8'h20, 10'd1, 8'h0F, 16'(i), 8'(i), 32'h9000), 1'b1);
      else begin
        beat(hdr(8'h40, 10'd1, 8'h0F, 16'(i), 8'(i), 32'h9000 + 32'(4 * i)), 1'b0);
        beat({96'h0, 32'(i * 32'h0101_0101)}, 1'b1);
      end
      if (i % 4 == 0) begin @(posedge clk); #1; end
    end
    stall_mode = 0;
    settle();
    chk(wq.size() == 0 && rq.size() == 0, "R11 all transfers delivered", wq.size() + rq.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R11 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule